// File: doc/BRIEF.md
# Chained-Switch Destination-Tag Route Selector

This block makes the per-packet routing decision for one stage of an eight-port multistage switching network. Each stage holds 2^n switches, and every switch has two normal outputs (upper and lower) plus a chain link to a sibling switch in the same stage. The decision is made without backtracking. The normal output comes from one bit of the packet's destination tag. When that output cannot be used, because its link or the next switch is flagged faulty or because the link does not exist in the last stage, the packet is sent sideways on the chain link. It keeps its tag unchanged.

The sibling reached by the chain depends on the stage number through a power-of-two modular offset. A parameter selects one of two variants: an up-chained network, where the offset is subtracted, or a down-chained network, where it is added. When the normal output and the chain are both blocked, the block flags the packet as dropped and reports its tag. One request is accepted per cycle, and its decision appears on registered outputs one cycle later.

Top module: `chain_route_stage`

## Requirements
- R1: While reset is high and in the first cycle after it, out_valid and out_drop are 0.
- R2: A request presented with req_valid=1 at one rising edge produces out_valid=1 after that edge. out_tag equals the request's req_tag.
- R3: In stage i (0 to n-1), destination bit n-1-i picks the normal output: 0 means upper (out_port=0) and 1 means lower (out_port=1). That output is used whenever it is available.
- R4: In the up-chained variant (CHAIN_DOWN=0), out_partner is (switch - 2^stage) mod 2^n.
- R5: In the down-chained variant (CHAIN_DOWN=1), out_partner is (switch + 2^stage) mod 2^n. For example, stage 1 switch 2 gives partner 4.
- R6: If the normal output is unavailable (fault_upper or fault_lower bit of the switch set), the packet leaves on the chain (out_port=2). This requires that fault_chain for the switch and fault_switch for the partner are both clear.
- R7: If the normal output is unavailable and the chain is blocked, out_drop=1 and out_port=3, and out_tag still carries the packet's tag.
- R8: In the last stage (stage n-1), the cross link of a switch is absent on one side. For a switch j, the straight output is the one whose index equals bit 0 of j. The up-chained variant lacks the lower output of even switches, and the down-chained variant lacks the upper output of odd switches. An absent output is treated as unavailable.
- R9: Fault flags on the output that is not selected, or on the chain when the normal output is usable, do not change out_port.
- R10: A cycle with req_valid=0 gives out_valid=0 and out_drop=0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A routing request is present |
| req_stage | input | STG_W | Stage number, 0 to N_LOG2-1 |
| req_switch | input | N_LOG2 | Index of the deciding switch |
| req_tag | input | N_LOG2 | Destination tag of the packet |
| fault_upper | input | 2^N_LOG2 | Per switch: upper output link or its next switch is faulty |
| fault_lower | input | 2^N_LOG2 | Per switch: lower output link or its next switch is faulty |
| fault_chain | input | 2^N_LOG2 | Per switch: chain-out link is faulty |
| fault_switch | input | 2^N_LOG2 | Per switch in this stage: switch is faulty (blocks chaining into it) |
| out_valid | output | 1 | Decision valid |
| out_port | output | 2 | 0 upper, 1 lower, 2 chain, 3 none (dropped) |
| out_partner | output | N_LOG2 | Chain partner switch index |
| out_tag | output | N_LOG2 | Destination tag carried with the decision |
| out_drop | output | 1 | Packet could not be routed |

## Verification
The hardest case to reach is a drop that comes from a fault on a *different* switch: the partner that the stage-dependent offset selects. The fault on the packet's own switch alone does not produce it. The vector table places the faulty-switch flag on the partner index computed for each entry. The random sweep then fills all four fault masks sparsely, so the partner's flag often lands on the right switch. Last-stage missing links are only reachable at stage n-1 with the matching switch parity. Both variants are instantiated side by side so that each parity is exercised.

// File: rtl/chain_route_pkg.sv
package chain_route_pkg;
  typedef enum logic [1:0] {
    PORT_UPPER = 2'd0,
    PORT_LOWER = 2'd1,
    PORT_CHAIN = 2'd2,
    PORT_NONE  = 2'd3
  } route_port_e;
endpackage

// File: rtl/chain_partner.sv
module chain_partner #(
  parameter int SW_W       = 3,
  parameter int STG_W      = 2,
  parameter bit CHAIN_DOWN = 1'b0
) (
  input  logic [SW_W-1:0]  self_idx,
  input  logic [STG_W-1:0] stage,
  output logic [SW_W-1:0]  partner
);
  logic [SW_W-1:0] offset;
  assign offset = SW_W'(1) << stage;

  // modulo 2^SW_W comes from truncation to SW_W bits
  generate
    if (CHAIN_DOWN) begin : g_down
      assign partner = self_idx + offset;
    end else begin : g_up
      assign partner = self_idx - offset;
    end
  endgenerate
endmodule

// File: rtl/route_select.sv
module route_select
  import chain_route_pkg::*;
#(
  parameter int N_LOG2     = 3,
  parameter int STG_W      = 2,
  parameter bit CHAIN_DOWN = 1'b0
) (
  input  logic [STG_W-1:0]  stage,
  input  logic [N_LOG2-1:0] self_idx,
  input  logic [N_LOG2-1:0] tag,
  input  logic              up_flt,
  input  logic              lo_flt,
  input  logic              chain_blocked,
  output route_port_e       port
);
  logic want_lo;
  logic last_stage;
  logic absent_up;
  logic absent_lo;
  logic up_ok;
  logic lo_ok;
  logic normal_ok;

  always_comb begin
    want_lo = 1'b0;
    for (int k = 0; k < N_LOG2; k++) begin
      if (stage == STG_W'(k)) want_lo = tag[N_LOG2-1-k];
    end
  end

  assign last_stage = (stage == STG_W'(N_LOG2-1));

  // the straight output of switch j is the one indexed by j[0]
  generate
    if (CHAIN_DOWN) begin : g_down
      assign absent_up = last_stage & self_idx[0];
      assign absent_lo = 1'b0;
    end else begin : g_up
      assign absent_up = 1'b0;
      assign absent_lo = last_stage & ~self_idx[0];
    end
  endgenerate

  assign up_ok     = ~up_flt & ~absent_up;
  assign lo_ok     = ~lo_flt & ~absent_lo;
  assign normal_ok = want_lo ? lo_ok : up_ok;

  always_comb begin
    if (normal_ok)           port = want_lo ? PORT_LOWER : PORT_UPPER;
    else if (!chain_blocked) port = PORT_CHAIN;
    else                     port = PORT_NONE;
  end
endmodule

// File: rtl/chain_route_stage.sv
module chain_route_stage
  import chain_route_pkg::*;
#(
  parameter int N_LOG2     = 3,
  parameter bit CHAIN_DOWN = 1'b0,
  localparam int NUM_SW    = 1 << N_LOG2,
  localparam int STG_W     = (N_LOG2 > 1) ? $clog2(N_LOG2) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [STG_W-1:0]  req_stage,
  input  logic [N_LOG2-1:0] req_switch,
  input  logic [N_LOG2-1:0] req_tag,
  input  logic [NUM_SW-1:0] fault_upper,
  input  logic [NUM_SW-1:0] fault_lower,
  input  logic [NUM_SW-1:0] fault_chain,
  input  logic [NUM_SW-1:0] fault_switch,
  output logic              out_valid,
  output logic [1:0]        out_port,
  output logic [N_LOG2-1:0] out_partner,
  output logic [N_LOG2-1:0] out_tag,
  output logic              out_drop
);
  logic [N_LOG2-1:0] partner;
  logic              chain_blocked;
  route_port_e       port_sel;

  chain_partner #(
    .SW_W(N_LOG2), .STG_W(STG_W), .CHAIN_DOWN(CHAIN_DOWN)
  ) u_partner (
    .self_idx(req_switch),
    .stage   (req_stage),
    .partner (partner)
  );

  assign chain_blocked = fault_chain[req_switch] | fault_switch[partner];

  route_select #(
    .N_LOG2(N_LOG2), .STG_W(STG_W), .CHAIN_DOWN(CHAIN_DOWN)
  ) u_select (
    .stage        (req_stage),
    .self_idx     (req_switch),
    .tag          (req_tag),
    .up_flt       (fault_upper[req_switch]),
    .lo_flt       (fault_lower[req_switch]),
    .chain_blocked(chain_blocked),
    .port         (port_sel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_drop    <= 1'b0;
      out_port    <= PORT_NONE;
      out_partner <= '0;
      out_tag     <= '0;
    end else begin
      out_valid <= req_valid;
      out_drop  <= req_valid && (port_sel == PORT_NONE);
      if (req_valid) begin
        out_port    <= port_sel;
        out_partner <= partner;
        out_tag     <= req_tag;
      end
    end
  end

  // R2
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid);

  // R10
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!out_valid && !out_drop));

  // R2
  tag_carry_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (out_tag == $past(req_tag)));

  // R7
  drop_port_chk: assert property (@(posedge clk) disable iff (rst)
    out_drop |-> (out_valid && out_port == PORT_NONE));

  // R6
  chain_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && fault_chain[req_switch]) |=> (out_port != PORT_CHAIN));
endmodule

// File: tb/chain_route_stage_bench.sv
module chain_route_stage_bench;
  localparam int NL = 3;
  localparam int NS = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_stage = '0;
  logic [NL-1:0] req_switch = '0, req_tag = '0;
  logic [NS-1:0] fu = '0, fl = '0, fc = '0, fs = '0;
  logic o_valid, o_drop, d_valid, d_drop;
  logic [1:0] o_port, d_port;
  logic [NL-1:0] o_partner, o_tag, d_partner, d_tag;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  chain_route_stage #(.N_LOG2(NL), .CHAIN_DOWN(1'b0)) u_chain_route_stage (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_stage(req_stage),
    .req_switch(req_switch), .req_tag(req_tag), .fault_upper(fu),
    .fault_lower(fl), .fault_chain(fc), .fault_switch(fs),
    .out_valid(o_valid), .out_port(o_port), .out_partner(o_partner),
    .out_tag(o_tag), .out_drop(o_drop));

  chain_route_stage #(.N_LOG2(NL), .CHAIN_DOWN(1'b1)) u_chain_route_stage_dn (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_stage(req_stage),
    .req_switch(req_switch), .req_tag(req_tag), .fault_upper(fu),
    .fault_lower(fl), .fault_chain(fc), .fault_switch(fs),
    .out_valid(d_valid), .out_port(d_port), .out_partner(d_partner),
    .out_tag(d_tag), .out_drop(d_drop));

  // entry: {stage[2], switch[3], tag[3], faults{partner_sw,chain,lower,upper}[4],
  //         expected up-variant port[2], expected up-variant partner[3]}
  localparam logic [16:0] VEC [10] = '{
    {2'd0, 3'd3, 3'b100, 4'b0000, 2'd1, 3'd2},
    {2'd1, 3'd2, 3'b000, 4'b0000, 2'd0, 3'd0},
    {2'd1, 3'd0, 3'b010, 4'b0010, 2'd2, 3'd6},
    {2'd0, 3'd5, 3'b011, 4'b0001, 2'd2, 3'd4},
    {2'd1, 3'd6, 3'b000, 4'b0101, 2'd3, 3'd4},
    {2'd0, 3'd1, 3'b100, 4'b1010, 2'd3, 3'd0},
    {2'd2, 3'd4, 3'b001, 4'b0000, 2'd2, 3'd0},
    {2'd2, 3'd5, 3'b001, 4'b0000, 2'd1, 3'd1},
    {2'd0, 3'd7, 3'b000, 4'b0110, 2'd0, 3'd6},
    {2'd2, 3'd4, 3'b000, 4'b0000, 2'd0, 3'd0}
  };

  function automatic int exp_partner(int down, int stage, int sw);
    if (down != 0) return (sw + (1 << stage)) % NS;
    return (sw - (1 << stage) + NS) % NS;
  endfunction

  function automatic int exp_port(int down, int stage, int sw, int tag,
                                  logic [NS-1:0] mu, logic [NS-1:0] ml,
                                  logic [NS-1:0] mc, logic [NS-1:0] ms);
    int want = (tag >> (NL - 1 - stage)) & 1;
    int p = exp_partner(down, stage, sw);
    bit last = (stage == NL - 1);
    bit abs_lo = last && (down == 0) && (sw % 2 == 0);
    bit abs_up = last && (down != 0) && (sw % 2 == 1);
    bit ok = (want != 0) ? (!ml[sw] && !abs_lo) : (!mu[sw] && !abs_up);
    if (ok) return want;
    if (!mc[sw] && !ms[p]) return 2;
    return 3;
  endfunction

  task automatic chk(string req, int act, int expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic issue(int stage, int sw, int tag);
    @(negedge clk);
    req_valid  = 1'b1;
    req_stage  = 2'(stage);
    req_switch = 3'(sw);
    req_tag    = 3'(tag);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic check_both(int stage, int sw, int tag);
    int eu = exp_port(0, stage, sw, tag, fu, fl, fc, fs);
    int ed = exp_port(1, stage, sw, tag, fu, fl, fc, fs);
    chk("R2 valid", int'(o_valid), 1);
    chk("R2 tag", int'(o_tag), tag);
    chk("R3/R6 up port", int'(o_port), eu);
    chk("R4 up partner", int'(o_partner), exp_partner(0, stage, sw));
    chk("R7 up drop", int'(o_drop), int'(eu == 3));
    chk("R3/R6 down port", int'(d_port), ed);
    chk("R5 down partner", int'(d_partner), exp_partner(1, stage, sw));
    chk("R7 down drop", int'(d_drop), int'(ed == 3));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed = 32'h1234_5678;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    chk("R1 valid in reset", int'(o_valid), 0);
    chk("R1 drop in reset", int'(o_drop), 0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R1 valid after reset", int'(o_valid), 0);
    chk("R1 drop after reset", int'(o_drop), 0);

    // table walk
    for (int e = 0; e < 10; e++) begin
      logic [16:0] v = VEC[e];
      int st = int'(v[16:15]);
      int sw = int'(v[14:12]);
      int tg = int'(v[11:9]);
      logic [3:0] f = v[8:5];
      int pu = int'(v[4:3]);
      int pp = int'(v[2:0]);
      fu = '0; fl = '0; fc = '0; fs = '0;
      fu[sw] = f[0]; fl[sw] = f[1]; fc[sw] = f[2]; fs[pp] = f[3];
      issue(st, sw, tg);
      chk(pu == 3 ? "R7 table port" : (pu == 2 ? "R6 table port" : "R3 table port"),
          int'(o_port), pu);
      chk("R4 table partner", int'(o_partner), pp);
      chk("R2 table tag", int'(o_tag), tg);
      chk("R7 table drop", int'(o_drop), int'(pu == 3));
    end

    // R5 example: stage 1 switch 2 chains to switch 4
    fu = '0; fl = '0; fc = '0; fs = '0;
    issue(1, 2, 0);
    chk("R5 down partner example", int'(d_partner), 4);

    // R8: last stage, down variant, odd switch, upper output absent
    issue(2, 3, 0);
    chk("R8 down odd upper absent", int'(d_port), 2);
    chk("R8 up odd upper present", int'(o_port), 0);
    // R8: down variant even switch lower output present
    issue(2, 2, 1);
    chk("R8 down even lower present", int'(d_port), 1);
    chk("R8 up even lower absent", int'(o_port), 2);

    // R9: faults on the unselected output and on the chain are ignored
    fl = '1; fc = '1; fs = '1;
    issue(1, 5, 0);
    chk("R9 up port unaffected", int'(o_port), 0);
    chk("R9 down port unaffected", int'(d_port), 0);
    fl = '0; fc = '0; fs = '0;

    // R10: idle cycle
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R10 idle valid", int'(o_valid), 0);
    chk("R10 idle drop", int'(d_drop), 0);

    // random sweep with sparse fault masks
    for (int it = 0; it < 400; it++) begin
      int st, sw, tg;
      seed = seed * 1103515245 + 12345; st = ((seed >>> 16) & 32'h7fff) % 3;
      seed = seed * 1103515245 + 12345; sw = (seed >>> 16) & 7;
      seed = seed * 1103515245 + 12345; tg = (seed >>> 16) & 7;
      seed = seed * 1103515245 + 12345; fu = 8'(seed >>> 8) & 8'(seed >>> 16);
      seed = seed * 1103515245 + 12345; fl = 8'(seed >>> 8) & 8'(seed >>> 16);
      seed = seed * 1103515245 + 12345; fc = 8'(seed >>> 8) & 8'(seed >>> 16);
      seed = seed * 1103515245 + 12345; fs = 8'(seed >>> 8) & 8'(seed >>> 16);
      issue(st, sw, tg);
      check_both(st, sw, tg);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule